// File: doc/BRIEF.md
# Multiplex-Aware Display RAM Loader

This block takes display data bytes from an upstream command decoder and stores them in a display memory of 160 columns by 4 rows. Each column corresponds to one segment output, and each row bit corresponds to one backplane. The block does not store a byte as one word. It spreads the byte's eight bits over as many columns as the selected drive mode needs: one row per column in static mode, and two, three or four rows per column in the multiplexed modes.

A column pointer chooses where the next byte lands. The decoder loads the pointer one nibble at a time and it then advances by itself after every byte. When the pointer runs past the last column it wraps to column 0 and pulses an output so that an outer subaddress counter can step. An abort input marks the pointer as untrustworthy, and the block refuses data until the pointer has been fully reloaded. A combinational read port exposes any column.

Top module: `disp_ram_loader`

## Requirements
- R1: After reset, `ptr` is 0, `ptr_ok` is 1, `sub_inc` is 0, and every memory bit reads 0.
- R2: `ld_hi` replaces pointer bits [7:4] with `nib`, and `ld_lo` replaces bits [3:0]. The other nibble keeps its current value. The new pointer is visible on the next cycle.
- R3: If a load would produce a pointer value of 160 or more, the pointer becomes 0 instead.
- R4: Mode value 0 is static. The byte's bits, most significant first, go to row 0 of eight successive columns starting at the pointer.
- R5: Mode value 1 is 1:2. The bits, most significant first, fill rows 0 and then 1 of four successive columns.
- R6: Mode value 2 is 1:3. The bits fill rows 0, 1 and 2 of the first two columns, then rows 0 and 1 of a third column. Row 2 of that third column keeps its old value.
- R7: Mode value 3 is 1:4. The bits fill rows 0 to 3 of two successive columns.
- R8: After an accepted byte, the pointer advances by 8, 4, 3 or 2 for modes 0, 1, 2 and 3 respectively.
- R9: Column addresses and the pointer wrap modulo 160. The cycle in which the pointer wraps has `sub_inc` high for exactly that one cycle.
- R10: A byte write changes only the row bits it targets. All other bits in the memory are left as they were.
- R11: `abort` drops `ptr_ok`. While `ptr_ok` is low, byte strobes change neither the memory nor the pointer. `ptr_ok` returns only after both an `ld_hi` and an `ld_lo` have been received following the abort, in either order.
- R12: A byte strobe in the same cycle as `abort`, `ld_hi` or `ld_lo` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | Drive mode: 0 static, 1 1:2, 2 1:3, 3 1:4 |
| ld_hi | input | 1 | Load the pointer high nibble from `nib` |
| ld_lo | input | 1 | Load the pointer low nibble from `nib` |
| nib | input | 4 | Nibble value for a pointer load |
| byte_we | input | 1 | Data byte strobe |
| byte_in | input | 8 | Data byte |
| abort | input | 1 | Transfer ended early; invalidates the pointer |
| rd_col | input | 8 | Column selected on the read port |
| rd_bits | output | 4 | Row bits of the selected column (bit n is row n) |
| ptr | output | 8 | Current column pointer |
| ptr_ok | output | 1 | Pointer is valid and bytes are accepted |
| sub_inc | output | 1 | One-cycle pulse when the pointer wraps |

## Verification
The bench builds the block with its default width of 160 columns. This keeps the wrap boundary at column 159, and an 8-bit pointer then has nibble combinations (high nibble A to F) that the clamp has to catch. Byte writes that start a few columns before 159 split across the boundary in every mode. With 1:3 mode's step of 3, a random run lands on pointer phases that never repeat in a short sequence, which checks the wrap arithmetic away from the aligned cases.

// File: rtl/disp_ram_loader.sv
module disp_ram_loader #(
  parameter int NCOL = 160
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode,
  input  logic       ld_hi,
  input  logic       ld_lo,
  input  logic [3:0] nib,
  input  logic       byte_we,
  input  logic [7:0] byte_in,
  input  logic       abort,
  input  logic [7:0] rd_col,
  output logic [3:0] rd_bits,
  output logic [7:0] ptr,
  output logic       ptr_ok,
  output logic       sub_inc
);
  localparam int ROWS = 4;
  localparam int BITS = 8;
  localparam logic [8:0] LIM = 9'(NCOL);

  logic [ROWS-1:0] mem [NCOL];
  logic            got_hi, got_lo;
  logic [7:0]      ld_val, ld_fix;
  logic [8:0]      step, sum, nxt;
  logic            wrap, go;
  logic [8:0]      wsum [BITS];
  logic [7:0]      wcol [BITS];
  logic [1:0]      wrow [BITS];
  logic [2:0]      woff [BITS];

  assign ld_val = {ld_hi ? nib : ptr[7:4], ld_lo ? nib : ptr[3:0]};
  assign ld_fix = ({1'b0, ld_val} >= LIM) ? 8'd0 : ld_val;
  assign go     = byte_we & ptr_ok & ~abort & ~ld_hi & ~ld_lo;

  always_comb begin
    case (mode)
      2'd0:    step = 9'd8;
      2'd1:    step = 9'd4;
      2'd2:    step = 9'd3;
      default: step = 9'd2;
    endcase
  end

  assign sum  = {1'b0, ptr} + step;
  assign wrap = sum >= LIM;
  assign nxt  = wrap ? sum - LIM : sum;

  always_comb begin
    for (int i = 0; i < BITS; i++) begin
      case (mode)
        2'd0:    begin woff[i] = 3'(i);     wrow[i] = 2'd0;      end
        2'd1:    begin woff[i] = 3'(i / 2); wrow[i] = 2'(i % 2); end
        2'd2:    begin woff[i] = 3'(i / 3); wrow[i] = 2'(i % 3); end
        default: begin woff[i] = 3'(i / 4); wrow[i] = 2'(i % 4); end
      endcase
      wsum[i] = {1'b0, ptr} + {6'd0, woff[i]};
      if (wsum[i] >= LIM) wsum[i] = wsum[i] - LIM;
      wcol[i] = wsum[i][7:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < NCOL; c++) mem[c] <= '0;
    end else if (go) begin
      for (int i = 0; i < BITS; i++) mem[wcol[i]][wrow[i]] <= byte_in[BITS-1-i];
    end
  end

  assign rd_bits = ({1'b0, rd_col} < LIM) ? mem[rd_col] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr     <= '0;
      ptr_ok  <= 1'b1;
      got_hi  <= 1'b0;
      got_lo  <= 1'b0;
      sub_inc <= 1'b0;
    end else begin
      sub_inc <= 1'b0;
      if (abort) begin
        ptr_ok <= 1'b0;
        got_hi <= 1'b0;
        got_lo <= 1'b0;
      end else if (ld_hi || ld_lo) begin
        ptr <= ld_fix;
        if (!ptr_ok && (got_hi || ld_hi) && (got_lo || ld_lo)) begin
          ptr_ok <= 1'b1;
          got_hi <= 1'b0;
          got_lo <= 1'b0;
        end else begin
          got_hi <= got_hi | ld_hi;
          got_lo <= got_lo | ld_lo;
        end
      end else if (go) begin
        ptr     <= nxt[7:0];
        sub_inc <= wrap;
      end
    end
  end

  a_r3_ptr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, ptr} < LIM);

  a_r9_wrap_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    sub_inc |-> ptr < $past(ptr));

  a_r8_ptr_moves: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_we && ptr_ok && !abort && !ld_hi && !ld_lo) |=> ptr != $past(ptr));

  a_r11_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (!ptr_ok && !abort && !ld_hi && !ld_lo) |=> ($stable(ptr) && !sub_inc && !ptr_ok));

  a_r11_abort_drops: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !ptr_ok);

  a_r11_regain_on_load: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ptr_ok) |-> $past(ld_hi || ld_lo));
endmodule

// File: tb/disp_ram_loader_tb.sv
module disp_ram_loader_tb;
  localparam int CLK_PER = 10;
  localparam int NC = 160;

  logic clk = 0, rst_n = 0;
  logic [1:0] mode = 0;
  logic ld_hi = 0, ld_lo = 0, byte_we = 0, abort = 0;
  logic [3:0] nib = 0;
  logic [7:0] byte_in = 0, rd_col = 0;
  logic [3:0] rd_bits;
  logic [7:0] ptr;
  logic ptr_ok, sub_inc;

  disp_ram_loader #(.NCOL(NC)) u_dut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .ld_hi(ld_hi), .ld_lo(ld_lo), .nib(nib),
    .byte_we(byte_we), .byte_in(byte_in), .abort(abort), .rd_col(rd_col),
    .rd_bits(rd_bits), .ptr(ptr), .ptr_ok(ptr_ok), .sub_inc(sub_inc));

  always #(CLK_PER/2) clk = ~clk;

  int n_run = 0, n_fail = 0, tick = 0;
  bit done = 0;
  string tag = "R1";
  int m_mem [NC][4];
  int m_ptr = 0;
  bit m_ok = 1, m_gh = 0, m_gl = 0, m_sub = 0;

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic int m_col(input int c);
    int v = 0;
    for (int r = 0; r < 4; r++) v += m_mem[c][r] << r;
    return v;
  endfunction

  task automatic model(input bit lh, input bit ll, input int n, input bit we,
                       input int d, input bit ab, input int md);
    m_sub = 0;
    if (ab) begin
      m_ok = 0; m_gh = 0; m_gl = 0;
    end else if (lh || ll) begin
      int v;
      v = (lh ? n : m_ptr / 16) * 16 + (ll ? n : m_ptr % 16);
      m_ptr = (v >= NC) ? 0 : v;
      m_gh |= lh; m_gl |= ll;
      if (!m_ok && m_gh && m_gl) begin m_ok = 1; m_gh = 0; m_gl = 0; end
    end else if (we && m_ok) begin
      int rows = md + 1;
      for (int i = 0; i < 8; i++)
        m_mem[(m_ptr + i / rows) % NC][i % rows] = (d >> (7 - i)) & 1;
      m_ptr += (8 + rows - 1) / rows;
      if (m_ptr >= NC) begin m_ptr -= NC; m_sub = 1; end
    end
  endtask

  task automatic cyc(input bit lh, input bit ll, input int n, input bit we,
                     input int d, input bit ab, input int md);
    ld_hi = lh; ld_lo = ll; nib = 4'(n); byte_we = we; byte_in = 8'(d);
    abort = ab; mode = 2'(md); rd_col = 8'((tick * 37) % NC);
    @(posedge clk);
    model(lh, ll, n, we, d, ab, md);
    tick++;
    @(negedge clk);
    ld_hi = 0; ld_lo = 0; byte_we = 0; abort = 0;
    chk(ptr == 8'(m_ptr), "ptr", ptr, m_ptr);
    chk(ptr_ok == m_ok, "ptr_ok", ptr_ok, m_ok);
    chk(sub_inc == m_sub, "sub_inc", sub_inc, m_sub);
    chk(rd_bits == 4'(m_col(rd_col)), "rd_bits", rd_bits, m_col(rd_col));
  endtask

  task automatic idle(input int md); cyc(0, 0, 0, 0, 0, 0, md); endtask
  task automatic load(input int v, input int md);
    cyc(1, 0, v / 16, 0, 0, 0, md);
    cyc(0, 1, v % 16, 0, 0, 0, md);
  endtask
  task automatic wr(input int d, input int md); cyc(0, 0, 0, 1, d, 0, md); endtask

  task automatic dump;
    for (int c = 0; c < NC; c++) begin
      rd_col = 8'(c);
      #1;
      chk(rd_bits == 4'(m_col(c)), "ram column", rd_bits, m_col(c));
    end
  endtask

  task automatic col_is(input int c, input int exp);
    rd_col = 8'(c);
    #1;
    chk(rd_bits == 4'(exp), "column bits", rd_bits, exp);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    tag = "watchdog";
    chk(0, "timeout", 0, 1);
    finish_run();
  end

  initial begin
    for (int c = 0; c < NC; c++) for (int r = 0; r < 4; r++) m_mem[c][r] = 0;
    repeat (3) @(posedge clk);
    rst_n = 1;
    @(negedge clk);
    tag = "R1";
    chk(ptr == 0, "reset ptr", ptr, 0);
    chk(ptr_ok == 1, "reset ptr_ok", ptr_ok, 1);
    chk(sub_inc == 0, "reset sub_inc", sub_inc, 0);
    dump();

    tag = "R2";
    cyc(1, 0, 3, 0, 0, 0, 0);
    chk(ptr == 8'h30, "high nibble", ptr, 8'h30);
    cyc(0, 1, 5, 0, 0, 0, 0);
    chk(ptr == 8'h35, "low nibble", ptr, 8'h35);

    tag = "R4";
    wr(8'hA5, 0);
    col_is(53, 1); col_is(54, 0); col_is(58, 1); col_is(60, 1);
    chk(ptr == 61, "static step", ptr, 61);

    tag = "R5";
    load(16, 1);
    wr(8'hC6, 1);
    col_is(16, 4'b0011); col_is(17, 4'b0000); col_is(18, 4'b0010); col_is(19, 4'b0001);
    chk(ptr == 20, "1:2 step", ptr, 20);

    tag = "R7";
    load(1, 3);
    wr(8'hFF, 3);
    col_is(1, 4'hF); col_is(2, 4'hF);
    chk(ptr == 3, "1:4 step", ptr, 3);

    tag = "R6";
    load(0, 2);
    wr(8'h00, 2);
    col_is(0, 4'b0000); col_is(1, 4'b1000);
    tag = "R10";
    col_is(2, 4'b1100);
    tag = "R8";
    chk(ptr == 3, "1:3 step", ptr, 3);

    tag = "R9";
    load(156, 0);
    wr(8'hFF, 0);
    chk(sub_inc == 1, "wrap pulse", sub_inc, 1);
    chk(ptr == 4, "wrapped ptr", ptr, 4);
    col_is(159, 1); col_is(3, 1);
    idle(0);
    chk(sub_inc == 0, "pulse width", sub_inc, 0);
    load(157, 2);
    wr(8'hB7, 2);
    chk(ptr == 0 && sub_inc == 1, "1:3 wrap", ptr, 0);

    tag = "R11";
    load(40, 3);
    cyc(0, 0, 0, 0, 0, 1, 3);
    chk(ptr_ok == 0, "abort", ptr_ok, 0);
    wr(8'hFF, 3);
    chk(ptr == 40, "blocked ptr", ptr, 40);
    col_is(40, 0);
    cyc(0, 1, 2, 0, 0, 0, 3);
    chk(ptr_ok == 0, "half reload", ptr_ok, 0);
    wr(8'hFF, 3);
    col_is(32, 0);
    cyc(1, 0, 2, 0, 0, 0, 3);
    chk(ptr_ok == 1 && ptr == 8'h22, "full reload", ptr, 8'h22);

    tag = "R12";
    cyc(1, 0, 5, 1, 8'hFF, 0, 3);
    chk(ptr == 8'h52, "strobe with load", ptr, 8'h52);
    col_is(8'h22, 0);
    cyc(0, 0, 0, 1, 8'hFF, 1, 3);
    col_is(8'h52, 0);
    load(8'h52, 3);

    tag = "R3";
    cyc(1, 0, 15, 0, 0, 0, 0);
    chk(ptr == 0, "clamp", ptr, 0);
    load(8'hA0, 0);
    chk(ptr == 0, "clamp 0xA0", ptr, 0);

    tag = "R8 R9 R10 R11";
    for (int k = 0; k < 2000; k++) begin
      int sel = $urandom_range(0, 19);
      int md = $urandom_range(0, 3);
      if (sel == 0)      cyc(0, 0, 0, $urandom_range(0, 1), $urandom_range(0, 255), 1, md);
      else if (sel == 1) cyc(1, 0, $urandom_range(0, 15), $urandom_range(0, 1), 0, 0, md);
      else if (sel == 2) cyc(0, 1, $urandom_range(0, 15), $urandom_range(0, 1), 0, 0, md);
      else if (sel < 5)  idle(md);
      else               wr($urandom_range(0, 255), md);
    end
    dump();
    finish_run();
  end
endmodule